// File: doc/BRIEF.md
# Delta-Sigma Result Serial Framer

This block takes finished conversion results (a 24-bit two's complement sample together with seven status bits) and sends each one over a single serial data line. It generates its own serial clock from the block clock. It announces each result with a one-period active-low ready strobe. It marks the 32-period frame that follows with an active-low frame strobe, and it raises a latch strobe at the end of each 16-period half of the frame. The receiver samples the data line on the falling serial clock edge. The block launches every bit on the rising edge and releases the line in the last period of the frame.

The block clock runs at twice the nominal master rate, so a serial clock at the master rate is a register toggling on every block clock. Two mode bits choose between the full rate and half that rate. A third input marks the lowest decimation setting. In that setting, frames follow one another with no gap, so the frame strobe stays low continuously, except for one divider/rate pairing. A result that arrives while a frame is being sent is held in a single-entry buffer and goes out right after the current frame. A newer arrival overwrites it. Any arrival during a frame sets a sticky overrun flag.

Top module: `serial_framer`

## Requirements
- R1: Each frame is announced by `drdy_n` going low for exactly one serial clock period; it changes only on rising `sclk` edges and is high at all other times.
- R2: `fsync_n` is low for exactly the 32 serial clock periods that follow the ready period, and high in the ready period and while idle (outside the continuous case of R8).
- R3: Frame periods 0 to 23 carry `smp_data` MSB first (period i carries bit 23-i); `sdo` changes only on a rising `sclk` edge, so it is stable at each falling edge.
- R4: Frame periods 24 to 30 carry `smp_stat` from bit 6 down to bit 0, where `smp_stat[6:4]` is the device address (high bit first), `[3]` the data-valid flag, `[2]` overrange, `[1]` low power and `[0]` filter settled.
- R5: `sdo_oe` is 1 in frame periods 0 to 30 and 0 in period 31, in the ready period and while idle.
- R6: `latch` is high in frame periods 15 and 31 and low in every other period.
- R7: The `sclk` period is 4 block clocks when `div_sel`=1 and `rate_sel`=1, and 2 block clocks for the other three pairings.
- R8: When `low_dec`=1 and not (`div_sel`=0 and `rate_sel`=1), `fsync_n` stays low in idle and ready periods as well; with `div_sel`=0, `rate_sel`=1 it pulses as in R2.
- R9: A result strobed in while a frame is in progress is announced in the period right after that frame's period 31.
- R10: When several results arrive during one frame, only the last of them is sent next.
- R11: `overrun` rises when `smp_stb` is seen while a frame is in progress (from the ready period through period 31) and stays high until reset.
- R12: While `rst_n` is low, `drdy_n` and `fsync_n` are 1 and `sdo_oe` and `overrun` are 0, whatever the mode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the nominal master rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | Clock divider select |
| rate_sel | input | 1 | Serial clock rate select |
| low_dec | input | 1 | Lowest decimation setting active |
| smp_data | input | 24 | Signed sample, two's complement |
| smp_stat | input | 7 | Status bits, layout as in R4 |
| smp_stb | input | 1 | One-cycle strobe: a new result is on smp_data/smp_stat |
| sclk | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data (0 when not enabled) |
| sdo_oe | output | 1 | Drive enable for the data line |
| drdy_n | output | 1 | Active-low data-ready strobe |
| fsync_n | output | 1 | Active-low frame strobe |
| latch | output | 1 | 16-bit latch strobe |
| overrun | output | 1 | Sticky flag: a result arrived during a frame |

## Verification
Single frames with random data, status bits and all eight mode combinations, sent with idle gaps between them, are compared bit by bit against a word built from the sent inputs. Patterns with alternating and extreme samples show whether the bit order and the status ordering are correct. Injecting one result in mid-frame separates correct back-to-back chaining from a dropped sample. Injecting two results separates replace-with-newest from keep-oldest. Idle periods in the continuous-frame modes and in their exception show whether the frame strobe is held low or pulsed, and a reset asserted in the continuous mode shows whether reset has priority over that mode.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sfr_sclk_gen.sv
module sfr_sclk_gen #(
    parameter int FAST_HALF = 1,
    parameter int SLOW_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    output logic sclk,
    output logic rise
);
    localparam int CNT_W = $clog2(SLOW_HALF) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        gen_d  = gen_q;
        rise   = 1'b0;
        last_d = slow ? CNT_W'(SLOW_HALF - 1) : CNT_W'(FAST_HALF - 1);
        if (gen_q.cnt >= last_d) begin
            gen_d.cnt  = '0;
            gen_d.sclk = ~gen_q.sclk;
            rise       = ~gen_q.sclk;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sclk = gen_q.sclk;
endmodule

// File: rtl/sfr_hold_buf.sv
module sfr_hold_buf #(
    parameter int WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_stb,
    input  logic [WORD_W-1:0] in_word,
    input  logic              busy,
    input  logic              take,
    output logic              pend_vld,
    output logic [WORD_W-1:0] pend_word,
    output logic              overrun
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              ovf;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (in_stb) begin
            buf_d.word = in_word;
            buf_d.vld  = 1'b1;
        end else if (take) begin
            buf_d.vld = 1'b0;
        end
        if (in_stb && busy) buf_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign pend_vld  = buf_q.vld;
    assign pend_word = buf_q.word;
    assign overrun   = buf_q.ovf;
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq #(
    parameter int WORD_W     = 31,
    parameter int FRAME_LEN  = 32,
    parameter int LATCH_SPAN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              pend_vld,
    input  logic [WORD_W-1:0] pend_word,
    input  logic              cont_fs,
    output logic              take,
    output logic              busy,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              drdy_n,
    output logic              fsync_n,
    output logic              latch
);
    import sfr_pkg::*;

    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam int LSB_W = $clog2(LATCH_SPAN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] sh;
        logic              sdo;
        logic              oe;
        logic              drdy_n;
        logic              fsync_n;
        logic              latch;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [IDX_W-1:0] nidx;
    logic             gap;

    always_comb begin
        seq_d = seq_q;
        take  = 1'b0;
        nidx  = seq_q.idx + 1'b1;
        gap   = 1'b0;
        if (rise) begin
            case (seq_q.st)
                ST_IDLE: gap = 1'b1;
                ST_READY: begin
                    seq_d.drdy_n  = 1'b1;
                    seq_d.fsync_n = 1'b0;
                    seq_d.idx     = '0;
                    seq_d.sdo     = seq_q.sh[WORD_W-1];
                    seq_d.sh      = {seq_q.sh[WORD_W-2:0], 1'b0};
                    seq_d.oe      = 1'b1;
                    seq_d.latch   = 1'b0;
                    seq_d.st      = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (seq_q.idx == LAST_IDX) begin
                        gap = 1'b1;
                    end else begin
                        seq_d.idx   = nidx;
                        seq_d.sdo   = seq_q.sh[WORD_W-1];
                        seq_d.sh    = {seq_q.sh[WORD_W-2:0], 1'b0};
                        seq_d.oe    = (nidx != LAST_IDX);
                        seq_d.latch = &nidx[LSB_W-1:0];
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
            if (gap) begin
                seq_d.fsync_n = ~cont_fs;
                seq_d.latch   = 1'b0;
                seq_d.oe      = 1'b0;
                seq_d.sdo     = 1'b0;
                seq_d.st      = ST_IDLE;
                if (pend_vld) begin
                    take         = 1'b1;
                    seq_d.sh     = pend_word;
                    seq_d.drdy_n = 1'b0;
                    seq_d.st     = ST_READY;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q         <= '0;
            seq_q.st      <= ST_IDLE;
            seq_q.drdy_n  <= 1'b1;
            seq_q.fsync_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.st != ST_IDLE);
    assign sdo     = seq_q.sdo;
    assign sdo_oe  = seq_q.oe;
    assign drdy_n  = seq_q.drdy_n;
    assign fsync_n = seq_q.fsync_n;
    assign latch   = seq_q.latch;
endmodule

// File: rtl/serial_framer.sv
module serial_framer #(
    parameter int DATA_W     = 24,
    parameter int STAT_W     = 7,
    parameter int LATCH_SPAN = 16,
    parameter int FAST_HALF  = 1,
    parameter int SLOW_HALF  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_sel,
    input  logic              rate_sel,
    input  logic              low_dec,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [STAT_W-1:0] smp_stat,
    input  logic              smp_stb,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              drdy_n,
    output logic              fsync_n,
    output logic              latch,
    output logic              overrun
);
    localparam int WORD_W    = DATA_W + STAT_W;
    localparam int FRAME_LEN = WORD_W + 1;

    logic              slow_rate;
    logic              cont_fs;
    logic              sclk_rise;
    logic              busy;
    logic              take;
    logic              pend_vld;
    logic [WORD_W-1:0] pend_word;

    assign slow_rate = div_sel & rate_sel;
    assign cont_fs   = low_dec & ~(~div_sel & rate_sel);

    sfr_sclk_gen #(
        .FAST_HALF(FAST_HALF),
        .SLOW_HALF(SLOW_HALF)
    ) clkgen_i (
        .clk  (clk),
        .rst_n(rst_n),
        .slow (slow_rate),
        .sclk (sclk),
        .rise (sclk_rise)
    );

    sfr_hold_buf #(
        .WORD_W(WORD_W)
    ) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_stb   (smp_stb),
        .in_word  ({smp_data, smp_stat}),
        .busy     (busy),
        .take     (take),
        .pend_vld (pend_vld),
        .pend_word(pend_word),
        .overrun  (overrun)
    );

    sfr_seq #(
        .WORD_W    (WORD_W),
        .FRAME_LEN (FRAME_LEN),
        .LATCH_SPAN(LATCH_SPAN)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (sclk_rise),
        .pend_vld (pend_vld),
        .pend_word(pend_word),
        .cont_fs  (cont_fs),
        .take     (take),
        .busy     (busy),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .drdy_n   (drdy_n),
        .fsync_n  (fsync_n),
        .latch    (latch)
    );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
    input logic clk,
    input logic rst_n,
    input logic div_sel,
    input logic rate_sel,
    input logic low_dec,
    input logic sclk,
    input logic sdo,
    input logic sdo_oe,
    input logic drdy_n,
    input logic fsync_n,
    input logic latch,
    input logic overrun
);
    logic cont_mode;
    assign cont_mode = low_dec & ~(~div_sel & rate_sel);

    assert_drdy_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drdy_n) |-> $rose(sclk));

    assert_ready_outside_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && !cont_mode) |-> fsync_n);

    assert_sdo_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $rose(sclk));

    assert_line_off_in_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_n |-> !sdo_oe);

    assert_latch_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !fsync_n);

    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_reset_state_R12: assert property (@(posedge clk)
        !rst_n |=> (drdy_n && fsync_n && !sdo_oe && !overrun));
endmodule

bind serial_framer sfr_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .rate_sel(rate_sel),
    .low_dec (low_dec),
    .sclk    (sclk),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .drdy_n  (drdy_n),
    .fsync_n (fsync_n),
    .latch   (latch),
    .overrun (overrun)
);

// File: tb/serial_framer_tb_top.sv
module serial_framer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        div_sel, rate_sel, low_dec;
    logic [23:0] smp_data;
    logic [6:0]  smp_stat;
    logic        smp_stb;
    logic        sclk, sdo, sdo_oe, drdy_n, fsync_n, latch, overrun;
    logic        sclk_old;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    serial_framer dut_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .rate_sel(rate_sel),
        .low_dec(low_dec), .smp_data(smp_data), .smp_stat(smp_stat),
        .smp_stb(smp_stb), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe),
        .drdy_n(drdy_n), .fsync_n(fsync_n), .latch(latch), .overrun(overrun)
    );

    always @(posedge clk) sclk_old <= sclk;

    function automatic logic [30:0] mk_word(input logic [23:0] d, input logic [6:0] s);
        return {d, s};
    endfunction

    function automatic int exp_period();
        return (div_sel && rate_sel) ? 4 : 2;
    endfunction

    function automatic logic exp_idle_fs();
        return !(low_dec && !(!div_sel && rate_sel));
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic next_period(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(sclk_old && !sclk));
    endtask

    task automatic pulse(input logic [30:0] w);
        smp_data = w[30:7];
        smp_stat = w[6:0];
        smp_stb  = 1'b1;
        @(posedge clk);
        #1 smp_stb = 1'b0;
    endtask

    task automatic send(input logic [30:0] w);
        @(negedge clk);
        pulse(w);
    endtask

    task automatic settle();
        int n;
        repeat (4) next_period(n);
    endtask

    task automatic run_frame(input logic [30:0] exp_w, input int inj_at, input int inj_n,
                             input logic [30:0] a_w, input logic [30:0] b_w,
                             input bit expect_next);
        int n;
        int guard = 0;
        logic idle_fs;
        idle_fs = exp_idle_fs();
        while (drdy_n && guard < 400) begin
            next_period(n);
            guard++;
        end
        chk("R1", "ready low before frame", drdy_n, 0);
        chk("R2", "frame strobe in ready period", fsync_n, idle_fs);
        chk("R5", "line released in ready period", sdo_oe, 0);
        for (int i = 0; i < 32; i++) begin
            next_period(n);
            chk("R7", "serial clock period", n, exp_period());
            chk("R1", "ready high inside frame", drdy_n, 1);
            chk("R2", "frame strobe low in frame", fsync_n, 0);
            chk("R5", "drive enable", sdo_oe, (i < 31) ? 1 : 0);
            chk("R6", "latch strobe", latch, (i == 15 || i == 31) ? 1 : 0);
            if (i < 24)      chk("R3", "data bit", sdo, exp_w[30-i]);
            else if (i < 31) chk("R4", "status bit", sdo, exp_w[30-i]);
            if (i == inj_at) pulse(a_w);
            if (inj_n == 2 && i == inj_at + 1) pulse(b_w);
        end
        next_period(n);
        if (expect_next) chk("R9", "next frame announced at once", drdy_n, 0);
        else             chk("R1", "ready stays high after frame", drdy_n, 1);
        chk("R2", "frame strobe after frame", fsync_n, idle_fs);
        chk("R5", "line released after frame", sdo_oe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [30:0] w, wa, wb, wc;
        int n;
        rst_n = 1'b0;
        div_sel = 1'b0; rate_sel = 1'b0; low_dec = 1'b1;
        smp_data = '0; smp_stat = '0; smp_stb = 1'b0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R12: reset state, even in the continuous-strobe mode
        chk("R12", "reset drdy_n", drdy_n, 1);
        chk("R12", "reset fsync_n", fsync_n, 1);
        chk("R12", "reset sdo_oe", sdo_oe, 0);
        chk("R12", "reset overrun", overrun, 0);
        low_dec = 1'b0;
        rst_n = 1'b1;
        settle();

        // directed patterns: extremes and alternating bits (R3, R4)
        w = mk_word(24'h800000, 7'b1010101); send(w); run_frame(w, -1, 0, '0, '0, 0);
        w = mk_word(24'h7FFFFF, 7'b0101010); send(w); run_frame(w, -1, 0, '0, '0, 0);
        w = mk_word(24'hA5A5A5, 7'b1110001); send(w); run_frame(w, -1, 0, '0, '0, 0);

        // random modes and words, idle gaps between frames
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            {div_sel, rate_sel, low_dec} = 3'($urandom);
            settle();
            chk("R8", "idle frame strobe level", fsync_n, exp_idle_fs());
            w = mk_word(24'($urandom), 7'($urandom));
            send(w);
            run_frame(w, -1, 0, '0, '0, 0);
            repeat (1 + ($urandom % 5)) next_period(n);
        end
        chk("R11", "no overrun without mid-frame arrivals", overrun, 0);

        // R9: one arrival during a frame goes out right after it
        @(negedge clk); div_sel = 1'b1; rate_sel = 1'b1; low_dec = 1'b0; settle();
        wa = mk_word(24'h123456, 7'b0011001);
        wb = mk_word(24'hFEDCBA, 7'b1100110);
        send(wa);
        run_frame(wa, 10, 1, wb, '0, 1);
        chk("R11", "overrun set by mid-frame arrival", overrun, 1);
        run_frame(wb, -1, 0, '0, '0, 0);

        // R10: two arrivals in one frame, newest wins
        @(negedge clk); div_sel = 1'b0; rate_sel = 1'b1; low_dec = 1'b0; settle();
        wa = mk_word(24'h0F0F0F, 7'b0000001);
        wb = mk_word(24'h111111, 7'b1111110);
        wc = mk_word(24'hC3C3C3, 7'b1001011);
        send(wa);
        run_frame(wa, 5, 2, wb, wc, 1);
        run_frame(wc, -1, 0, '0, '0, 0);
        chk("R10", "no further frame after newest", drdy_n, 1);
        settle();
        chk("R11", "overrun still set", overrun, 1);

        // R8: continuous strobe versus its pulsed exception
        @(negedge clk); div_sel = 1'b0; rate_sel = 1'b0; low_dec = 1'b1; settle();
        for (int i = 0; i < 3; i++) begin
            next_period(n);
            chk("R8", "continuous mode idle strobe low", fsync_n, 0);
        end
        w = mk_word(24'h5A5A5A, 7'b0110100); send(w); run_frame(w, -1, 0, '0, '0, 0);
        @(negedge clk); div_sel = 1'b0; rate_sel = 1'b1; low_dec = 1'b1; settle();
        chk("R8", "exception mode idle strobe high", fsync_n, 1);
        w = mk_word(24'h3C3C3C, 7'b1011010); send(w); run_frame(w, -1, 0, '0, '0, 0);

        // R12: reset in continuous mode clears overrun and raises strobes
        @(negedge clk); div_sel = 1'b1; rate_sel = 1'b0; low_dec = 1'b1; settle();
        chk("R8", "continuous mode with divider 1 rate 0", fsync_n, 0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "reset fsync_n in continuous mode", fsync_n, 1);
        chk("R12", "reset overrun cleared", overrun, 0);
        chk("R12", "reset drdy_n", drdy_n, 1);
        chk("R12", "reset sdo_oe", sdo_oe, 0);
        rst_n = 1'b1;
        settle();
        w = mk_word(24'h654321, 7'b0101101); send(w); run_frame(w, -1, 0, '0, '0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule